// File: doc/BRIEF.md
# RMII Receive Di-bit Deserializer

This block is the receive half of a MAC attached to a Reduced Media Independent Interface. Each cycle of the 50 MHz reference clock it samples the carrier/data-valid strobe, the two receive data lines and the receive error line. While the strobe is high, the two data lines carry two recovered bits. The block ignores the line while the strobe is low. It also ignores any zero di-bits that appear before decoding has settled. It locks onto the start of the frame and packs the di-bits that follow into bytes.

The bytes leave on a single-beat stream with valid and last markers. The last beat of a frame carries two status bits. One reports a receive-symbol error seen anywhere in the frame. The other reports that the frame ended part way through a byte. The block holds each finished byte for one byte-time so that it can mark the final byte of the frame as last once the strobe falls.

An optional input register stage, selected by a parameter, isolates the pads from the decode logic. The lane width and output byte width are parameters, and so are the preamble code and the delimiter code.

Top module: `rmii_rx_deser`

## Requirements
- R1: After reset, byte_valid_o, byte_last_o, frame_err_o and align_err_o are all 0, and they stay 0 until a frame is received.
- R2: Alignment. The receiver waits until it sees one or more di-bits 2'b01 followed directly by the di-bit 2'b11. Zero di-bits in front of the 2'b01 run are skipped. Any di-bit other than 2'b01 or 2'b11 after a 2'b01 sends it back to waiting. A lone 2'b11 never aligns it. The first byte starts with the di-bit after the 2'b11.
- R3: Packing is least-significant first. Di-bit k of a byte (k = 0..3) lands in bits [2k+1:2k] of byte_data_o.
- R4: Each completed byte is presented exactly once, in arrival order, for one cycle with byte_valid_o = 1. It appears when the next byte completes or when the frame ends. On a beat that is not last, byte_last_o, frame_err_o and align_err_o are 0.
- R5: When crs_dv_i is sampled low after alignment, the final completed byte is presented with byte_last_o = 1. No beat follows a last beat in the next cycle.
- R6: If rx_er_i is high in any cycle in which crs_dv_i is high, from the first di-bit of the frame to its last, frame_err_o = 1 on that frame's last beat. The flag is cleared before the next frame.
- R7: rx_er_i has no effect while crs_dv_i is low. A pulse in the gap between frames does not set frame_err_o for either neighbouring frame.
- R8: If the frame ends with 1 to 3 di-bits of an incomplete byte, those di-bits are dropped and the preceding byte is marked last with align_err_o = 1. If no byte completed at all, nothing is emitted.
- R9: A frame that ends before the 2'b01 / 2'b11 delimiter pair produces no bytes and no last beat.
- R10: rxd_i is ignored while crs_dv_i is low. A preamble and delimiter pattern driven during the gap does not align the receiver. After crs_dv_i has been low for four consecutive cycles, no byte is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 50 MHz reference clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| crs_dv_i | input | 1 | Carrier sense / receive data valid |
| rxd_i | input | LANE_W (2) | Received di-bit |
| rx_er_i | input | 1 | Receive symbol error |
| byte_valid_o | output | 1 | Byte beat valid (one cycle) |
| byte_data_o | output | DATA_W (8) | Assembled byte |
| byte_last_o | output | 1 | Beat is the final byte of the frame |
| frame_err_o | output | 1 | Symbol error seen in frame (on last beat) |
| align_err_o | output | 1 | Frame ended inside a byte (on last beat) |

## Verification
The bench builds the block with its defaults: 2-bit lanes, 8-bit bytes, the input register stage on, and codes 2'b01 and 2'b11. Because a byte is only four di-bits, a full sweep is possible. It covers 0 to 3 leading zero di-bits, 1 to 3 preamble di-bits, 0 to 5 whole bytes and 0 to 3 trailing di-bits, with the error pulse either absent or placed at a chosen di-bit. This reaches every residue at frame end and every error position class. Directed frames cover a broken preamble, a frame with no delimiter and a delimiter pattern driven while the strobe is low.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;

   // Alignment phases of the receive hunt machine.
   typedef enum logic [1:0] {
      ST_HUNT = 2'd0,
      ST_PRE  = 2'd1,
      ST_BODY = 2'd2
   } align_st_e;

endpackage

// File: rtl/rmii_rx_sampler.sv
// Input capture: optional register stage, then masking of data and error
// while the carrier strobe is low.
module rmii_rx_sampler #(
   parameter int unsigned LANE_W = 2,
   parameter bit          IN_REG = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              crs_dv_i,
   input  logic [LANE_W-1:0] rxd_i,
   input  logic              rx_er_i,
   output logic              crs_o,
   output logic [LANE_W-1:0] lane_o,
   output logic              er_o
);

   logic              crs_s;
   logic [LANE_W-1:0] rxd_s;
   logic              er_s;

   generate
      if (IN_REG) begin : g_reg
         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               crs_s <= 1'b0;
               rxd_s <= '0;
               er_s  <= 1'b0;
            end else begin
               crs_s <= crs_dv_i;
               rxd_s <= rxd_i;
               er_s  <= rx_er_i;
            end
         end
      end else begin : g_thru
         assign crs_s = crs_dv_i;
         assign rxd_s = rxd_i;
         assign er_s  = rx_er_i;
      end
   endgenerate

   // Data and error are only meaningful under carrier.
   assign crs_o  = crs_s;
   assign lane_o = crs_s ? rxd_s : '0;
   assign er_o   = crs_s & er_s;

endmodule

// File: rtl/rmii_rx_aligner.sv
// Hunts for the preamble/delimiter pair and qualifies body di-bits.
module rmii_rx_aligner
   import rmii_rx_pkg::*;
#(
   parameter int unsigned       LANE_W   = 2,
   parameter logic [LANE_W-1:0] PRE_CODE = 2'b01,
   parameter logic [LANE_W-1:0] SFD_CODE = 2'b11
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              crs_i,
   input  logic [LANE_W-1:0] lane_i,
   output logic              lane_vld_o,
   output logic              frame_end_o
);

   align_st_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (!crs_i) begin
         st_d = ST_HUNT;
      end else begin
         unique case (st_q)
            ST_HUNT: if (lane_i == PRE_CODE) st_d = ST_PRE;
            ST_PRE: begin
               if (lane_i == SFD_CODE)      st_d = ST_BODY;
               else if (lane_i != PRE_CODE) st_d = ST_HUNT;
            end
            ST_BODY: st_d = ST_BODY;
            default: st_d = ST_HUNT;
         endcase
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) st_q <= ST_HUNT;
      else         st_q <= st_d;
   end

   assign lane_vld_o  = crs_i  && (st_q == ST_BODY);
   assign frame_end_o = !crs_i && (st_q == ST_BODY);

endmodule

// File: rtl/rmii_rx_errflag.sv
// Sticky per-frame symbol-error flag, cleared while carrier is absent.
module rmii_rx_errflag (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic crs_i,
   input  logic er_i,
   output logic seen_o
);

   logic seen_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)     seen_q <= 1'b0;
      else if (!crs_i) seen_q <= 1'b0;
      else if (er_i)   seen_q <= 1'b1;
   end

   assign seen_o = seen_q;

endmodule

// File: rtl/rmii_rx_packer.sv
// Packs qualified di-bits LSB-first into bytes, keeps one finished byte in
// reserve so the final byte can be tagged last with frame status.
module rmii_rx_packer #(
   parameter int unsigned LANE_W = 2,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              lane_vld_i,
   input  logic [LANE_W-1:0] lane_i,
   input  logic              frame_end_i,
   input  logic              err_seen_i,
   output logic              byte_valid_o,
   output logic [DATA_W-1:0] byte_data_o,
   output logic              byte_last_o,
   output logic              frame_err_o,
   output logic              align_err_o
);

   localparam int unsigned LANES = DATA_W / LANE_W;
   localparam int unsigned CNT_W = (LANES > 2) ? $clog2(LANES) : 1;
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(LANES - 1);

   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] acc_q;
   logic [DATA_W-1:0] acc_nxt;
   logic [DATA_W-1:0] hold_q;
   logic              hold_vld_q;
   logic              byte_done;

   assign acc_nxt   = {lane_i, acc_q[DATA_W-1:LANE_W]};
   assign byte_done = lane_vld_i && (cnt_q == CNT_TOP);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q        <= '0;
         acc_q        <= '0;
         hold_q       <= '0;
         hold_vld_q   <= 1'b0;
         byte_valid_o <= 1'b0;
         byte_data_o  <= '0;
         byte_last_o  <= 1'b0;
         frame_err_o  <= 1'b0;
         align_err_o  <= 1'b0;
      end else begin
         byte_valid_o <= 1'b0;
         byte_last_o  <= 1'b0;
         frame_err_o  <= 1'b0;
         align_err_o  <= 1'b0;
         if (lane_vld_i) begin
            acc_q <= acc_nxt;
            if (byte_done) begin
               cnt_q      <= '0;
               hold_q     <= acc_nxt;
               hold_vld_q <= 1'b1;
               if (hold_vld_q) begin
                  byte_valid_o <= 1'b1;
                  byte_data_o  <= hold_q;
               end
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         if (frame_end_i) begin
            cnt_q      <= '0;
            hold_vld_q <= 1'b0;
            if (hold_vld_q) begin
               byte_valid_o <= 1'b1;
               byte_data_o  <= hold_q;
               byte_last_o  <= 1'b1;
               frame_err_o  <= err_seen_i;
               align_err_o  <= (cnt_q != '0);
            end
         end
      end
   end

endmodule

// File: rtl/rmii_rx_deser.sv
module rmii_rx_deser #(
   parameter int unsigned       LANE_W   = 2,
   parameter int unsigned       DATA_W   = 8,
   parameter bit                IN_REG   = 1'b1,
   parameter logic [LANE_W-1:0] PRE_CODE = 2'b01,
   parameter logic [LANE_W-1:0] SFD_CODE = 2'b11
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              crs_dv_i,
   input  logic [LANE_W-1:0] rxd_i,
   input  logic              rx_er_i,
   output logic              byte_valid_o,
   output logic [DATA_W-1:0] byte_data_o,
   output logic              byte_last_o,
   output logic              frame_err_o,
   output logic              align_err_o
);

   localparam int unsigned LANES = DATA_W / LANE_W;

   generate
      if ((DATA_W % LANE_W) != 0) begin : g_bad_ratio
         $error("DATA_W must be a multiple of LANE_W");
      end
      if (LANES < 2) begin : g_bad_lanes
         $error("DATA_W must hold at least two lanes");
      end
      if (PRE_CODE == SFD_CODE) begin : g_bad_codes
         $error("preamble and delimiter codes must differ");
      end
   endgenerate

   logic              crs_w;
   logic [LANE_W-1:0] lane_w;
   logic              er_w;
   logic              lane_vld_w;
   logic              frame_end_w;
   logic              err_seen_w;

   rmii_rx_sampler #(.LANE_W(LANE_W), .IN_REG(IN_REG)) u_smp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .crs_dv_i(crs_dv_i),
      .rxd_i   (rxd_i),
      .rx_er_i (rx_er_i),
      .crs_o   (crs_w),
      .lane_o  (lane_w),
      .er_o    (er_w)
   );

   rmii_rx_aligner #(.LANE_W(LANE_W), .PRE_CODE(PRE_CODE), .SFD_CODE(SFD_CODE)) u_aln (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .crs_i      (crs_w),
      .lane_i     (lane_w),
      .lane_vld_o (lane_vld_w),
      .frame_end_o(frame_end_w)
   );

   rmii_rx_errflag u_err (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .crs_i (crs_w),
      .er_i  (er_w),
      .seen_o(err_seen_w)
   );

   rmii_rx_packer #(.LANE_W(LANE_W), .DATA_W(DATA_W)) u_pack (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .lane_vld_i  (lane_vld_w),
      .lane_i      (lane_w),
      .frame_end_i (frame_end_w),
      .err_seen_i  (err_seen_w),
      .byte_valid_o(byte_valid_o),
      .byte_data_o (byte_data_o),
      .byte_last_o (byte_last_o),
      .frame_err_o (frame_err_o),
      .align_err_o (align_err_o)
   );

endmodule

// File: rtl/rmii_rx_chk.sv
module rmii_rx_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic crs_dv_i,
   input logic byte_valid_o,
   input logic byte_last_o,
   input logic frame_err_o,
   input logic align_err_o
);

   logic [1:0] cyc_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)           cyc_q <= '0;
      else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
   end

   // R5: a last marker only rides on a valid beat
   p_last_on_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      byte_last_o |-> byte_valid_o);

   // R4: status bits appear only on the last beat
   p_status_on_last_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frame_err_o || align_err_o) |-> byte_last_o);

   // R5: nothing follows a last beat directly
   p_quiet_after_last_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      byte_last_o |=> !byte_valid_o);

   // R10: long carrier absence drains the output
   p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((cyc_q == 2'd3) && !crs_dv_i && !$past(crs_dv_i) && !$past(crs_dv_i, 2)
       && !$past(crs_dv_i, 3)) |-> !byte_valid_o);

   // R1: first cycle after reset is silent
   p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_q == 2'd0) |-> !byte_valid_o);

endmodule

bind rmii_rx_deser rmii_rx_chk u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .crs_dv_i    (crs_dv_i),
   .byte_valid_o(byte_valid_o),
   .byte_last_o (byte_last_o),
   .frame_err_o (frame_err_o),
   .align_err_o (align_err_o)
);

// File: tb/sim_rmii_rx_deser.sv
module sim_rmii_rx_deser;

   typedef struct {
      logic [7:0] d;
      logic       last;
      logic       ferr;
      logic       aerr;
   } beat_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       crs = 1'b0;
   logic [1:0] rxd = 2'b00;
   logic       er = 1'b0;
   logic       vld, last, ferr, aerr;
   logic [7:0] dat;

   int    errors = 0;
   int    checks = 0;
   int    cycles = 0;
   bit    done = 1'b0;
   string cur_tag = "R1";
   beat_t exp_q[$];
   logic [1:0] dq[$];

   always #2 clk = ~clk;

   rmii_rx_deser u0 (
      .clk_i(clk), .rst_ni(rst_n), .crs_dv_i(crs), .rxd_i(rxd), .rx_er_i(er),
      .byte_valid_o(vld), .byte_data_o(dat), .byte_last_o(last),
      .frame_err_o(ferr), .align_err_o(aerr)
   );

   function automatic logic [7:0] bval(input int seed, input int i);
      return 8'((seed * 29 + i * 53 + 7) & 255);
   endfunction

   // Monitor: every beat is compared in order with the expected stream.
   always @(negedge clk) begin
      beat_t b;
      if (rst_n && vld && !done) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL %s: unexpected beat data=%h last=%b, expected none", cur_tag, dat, last);
         end else begin
            b = exp_q.pop_front();
            if (dat !== b.d || last !== b.last || ferr !== b.ferr || aerr !== b.aerr) begin
               errors++;
               $display("FAIL %s (%s): got d=%h l=%b fe=%b ae=%b, expected d=%h l=%b fe=%b ae=%b",
                        cur_tag, b.last ? "R5" : "R4", dat, last, ferr, aerr,
                        b.d, b.last, b.ferr, b.aerr);
            end
         end
      end
   end

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles >= 190000 && !done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: %0d cycles, expected completion", cycles);
         summary();
         $finish;
      end
   end

   // Drive the queued di-bits under carrier, then a gap with garbage on
   // RXD (including 01,11) and an error pulse (R7, R10).
   task automatic drive(input int er_at);
      for (int k = 0; k < dq.size(); k++) begin
         @(negedge clk);
         crs = 1'b1; rxd = dq[k]; er = (k == er_at);
      end
      for (int g = 0; g < 8; g++) begin
         @(negedge clk);
         crs = 1'b0; rxd = (g % 2 == 1) ? 2'b11 : 2'b01; er = (g == 2);
      end
      @(negedge clk);
      rxd = 2'b00; er = 1'b0;
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL %s: %0d beats pending, expected 0", cur_tag, exp_q.size());
         exp_q.delete();
      end
   endtask

   task automatic push_byte(input logic [7:0] v, input int ndib);
      for (int k = 0; k < ndib; k++) dq.push_back(2'((v >> (2 * k)) & 8'h3));
   endtask

   task automatic frame(input int nz, input int npre, input int nb, input int extra,
                        input int er_at, input int seed, input string tag);
      beat_t b;
      cur_tag = tag;
      dq.delete();
      for (int k = 0; k < nz; k++)   dq.push_back(2'b00);
      for (int k = 0; k < npre; k++) dq.push_back(2'b01);
      dq.push_back(2'b11);
      for (int i = 0; i < nb; i++) push_byte(bval(seed, i), 4);
      push_byte(bval(seed, nb), extra);
      for (int i = 0; i < nb; i++) begin
         b.d    = bval(seed, i);
         b.last = (i == nb - 1);
         b.ferr = b.last && (er_at >= 0) && (er_at < dq.size());
         b.aerr = b.last && (extra > 0);
         exp_q.push_back(b);
      end
      drive(er_at);
   endtask

   initial begin
      int seed;
      int er_at;
      beat_t b;
      string tag;
      seed = 1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1: silent after reset, even with garbage RXD while carrier is low
      for (int c = 0; c < 6; c++) begin
         @(negedge clk);
         rxd = 2'(c);
         checks++;
         if (vld !== 1'b0 || last !== 1'b0 || ferr !== 1'b0 || aerr !== 1'b0) begin
            errors++;
            $display("FAIL R1: outputs v=%b l=%b fe=%b ae=%b, expected 0", vld, last, ferr, aerr);
         end
      end
      rxd = 2'b00;

      // R3/R6/R8 sweep over leading zeros, preamble length, body, residue
      for (int nz = 0; nz < 4; nz++)
         for (int np = 1; np < 4; np++)
            for (int nb = 0; nb < 6; nb++)
               for (int ex = 0; ex < 4; ex++) begin
                  seed++;
                  if (seed % 3 == 0) er_at = -1;
                  else er_at = (seed * 7) % (nz + np + 1 + nb * 4 + ex);
                  tag = (ex > 0) ? "R8" : ((er_at >= 0) ? "R6" : "R3");
                  frame(nz, np, nb, ex, er_at, seed, tag);
               end

      // R7: error only in the gap (drive adds one) -> clean frame after it
      frame(2, 3, 3, 0, -1, 77, "R7");

      // R2: 01 followed by 10 breaks the hunt; later 01,11 aligns
      cur_tag = "R2";
      dq.delete();
      dq.push_back(2'b00); dq.push_back(2'b01); dq.push_back(2'b10); dq.push_back(2'b11);
      push_byte(8'h00, 4);
      dq.push_back(2'b01); dq.push_back(2'b11);
      push_byte(8'hA5, 4); push_byte(8'h3C, 4);
      b.d = 8'hA5; b.last = 1'b0; b.ferr = 1'b0; b.aerr = 1'b0; exp_q.push_back(b);
      b.d = 8'h3C; b.last = 1'b1; exp_q.push_back(b);
      drive(-1);

      // R9: carrier ends before any delimiter
      cur_tag = "R9";
      dq.delete();
      dq.push_back(2'b00); dq.push_back(2'b00);
      for (int k = 0; k < 5; k++) dq.push_back(2'b01);
      dq.push_back(2'b10);
      push_byte(8'hFF, 4);
      drive(3);

      // R10: 01,11 driven with carrier low, then body with no preamble
      cur_tag = "R10";
      dq.delete();
      push_byte(8'hFF, 4); push_byte(8'h22, 4); push_byte(8'hFF, 4);
      drive(-1);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule